// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block produces the 16-bit address of a load operand for a small processor that has an 8-bit data path and a 16-bit address path. It also loads the accumulator with the byte read from that address. An instruction begins with a start strobe in its opcode cycle. The mode select taken in that cycle picks one of two forms:

- **Direct form.** One operand byte follows the opcode. The target is that byte added to a programmable direct-page base.
- **Absolute form.** Two operand bytes follow the opcode, low byte first. Together they give the full 16-bit address.

The direct window is 256 bytes long and starts wherever the base register points, so it is not fixed at physical page zero. A direct load spans three clock cycles: opcode, operand, read. An absolute load spans four: opcode, low byte, high byte, read. The block counts the cycles each instruction occupies and reports that count once the load completes.

The base register is written through a dedicated strobe and data port. A new base value takes effect from the next instruction. An instruction already under way keeps the base that was current when it started.

Top module: `dp_ea_gen`

## Requirements
- R1: After reset the accumulator is 0x00 and the direct-page base is 0x0000. The read request, the done pulse and the busy flag are all low.
- R2: Direct form (mode select 0 at start) places the operand byte in the cycle after start. The read request is high in the third cycle of the instruction. The read address is the base plus the zero-extended operand byte.
- R3: Absolute form (mode select 1 at start) takes the low address byte in the cycle after start and the high byte in the cycle after that. The read request is high in the fourth cycle of the instruction, with the address formed as {high, low}.
- R4: In the cycle after the read request, done is high for exactly one cycle and the accumulator holds the byte that was on the read-data input during the read cycle.
- R5: While done is high, the cycle-count output reads 3 after a direct load and 4 after an absolute load.
- R6: A base write is visible only to instructions whose start comes after the write cycle. A write made during an instruction, or in the same cycle as its start, does not change that instruction's address.
- R7: The direct-form sum is truncated to 16 bits, so base 0xFFF0 with operand 0x20 reads address 0x0010.
- R8: A direct load of operand 0x12 with base 0x0000 and an absolute load of 0x0012 read the same address and load the same accumulator value. With a base of 0x0100 or more (and no wrap), a direct load never reads addresses 0x0000 to 0x00FF.
- R9: A start strobe while busy is high is ignored. The running instruction keeps its mode, address and cycle count, and no further instruction starts after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opcode cycle strobe; begins an instruction when idle |
| mode_abs_i | input | 1 | Mode at start: 0 direct, 1 absolute |
| instr_byte_i | input | 8 | Instruction-stream byte for the current cycle |
| base_we_i | input | 1 | Direct-page base write strobe |
| base_wdata_i | input | 16 | New direct-page base value |
| rd_data_i | input | 8 | Memory read data, sampled in the read-request cycle |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 16 | Memory read address |
| acc_o | output | 8 | Accumulator |
| done_o | output | 1 | One-cycle pulse when the accumulator is updated |
| busy_o | output | 1 | High from the cycle after start through the read cycle |
| cycles_o | output | 3 | Cycle count of the most recent completed load |

## Verification
The assertions assume that read data is valid within the read-request cycle itself, so the memory behind the block must answer combinationally from the address. They also assume that a start strobe arrives only while the block is idle or is deliberately a stray one to be ignored. The bench supplies memory as a pure function of the address, which meets the first assumption. It issues starts only in idle cycles, except for one test that injects a stray start in mid-instruction. Base writes are placed both between instructions and inside them, so both sides of the next-instruction rule are exercised.

// File: rtl/dp_ea_pkg.sv
package dp_ea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPLO = 2'd1,
        ST_OPHI = 2'd2,
        ST_READ = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dp_base_reg.sv
module dp_base_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          capture_i,
    output logic [AW-1:0] base_act_o
);

    typedef struct packed {
        logic [AW-1:0] shadow;
        logic [AW-1:0] act;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) st_d.act = st_q.shadow;
        if (we_i)      st_d.shadow = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_act_o = st_q.act;

    // R6: the base in use moves only when an instruction begins
    assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(base_act_o));

    // R6: a write in the start cycle is not what the instruction sees
    assert_capture_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && we_i && (wdata_i != st_q.shadow)) |=> (base_act_o != $past(wdata_i)));

endmodule

// File: rtl/dp_ea_form.sv
module dp_ea_form #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo_i,
    input  logic          ld_hi_i,
    input  logic          ld_dir_i,
    input  logic [DW-1:0] byte_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] ea_o
);

    localparam int WIN = 1 << DW;
    localparam int HW  = AW - DW;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [AW-1:0] ea;
    } ea_st_t;

    ea_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo_i)  st_d.lo = byte_i;
        if (ld_dir_i) st_d.ea = base_i + AW'(byte_i);
        if (ld_hi_i)  st_d.ea = {byte_i[HW-1:0], st_q.lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ea_o = st_q.ea;

    // R2: a direct address lies within the 256-byte window above the base
    assert_dir_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dir_i |=> (int'(AW'(ea_o - $past(base_i))) < WIN));

    // R3: the high byte of an absolute address comes from the later fetch
    assert_abs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi_i |=> (ea_o[AW-1:DW] == $past(byte_i[HW-1:0])));

endmodule

// File: rtl/dp_ea_seq.sv
module dp_ea_seq
    import dp_ea_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_abs_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          capture_o,
    output logic          ld_lo_o,
    output logic          ld_hi_o,
    output logic          ld_dir_o,
    output logic          rd_req_o,
    output logic          busy_o,
    output logic [DW-1:0] acc_o,
    output logic          done_o,
    output logic [CW-1:0] cycles_o
);

    typedef struct packed {
        seq_state_e    state;
        logic          abs_mode;
        logic [CW-1:0] cnt;
        logic [DW-1:0] acc;
        logic          done;
        logic [CW-1:0] cycles;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        capture_o = 1'b0;
        ld_lo_o   = 1'b0;
        ld_hi_o   = 1'b0;
        ld_dir_o  = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.state    = ST_OPLO;
                    st_d.abs_mode = mode_abs_i;
                    st_d.cnt      = CW'(1);
                    capture_o     = 1'b1;
                end
            end
            ST_OPLO: begin
                ld_lo_o    = st_q.abs_mode;
                ld_dir_o   = !st_q.abs_mode;
                st_d.cnt   = st_q.cnt + CW'(1);
                st_d.state = st_q.abs_mode ? ST_OPHI : ST_READ;
            end
            ST_OPHI: begin
                ld_hi_o    = 1'b1;
                st_d.cnt   = st_q.cnt + CW'(1);
                st_d.state = ST_READ;
            end
            ST_READ: begin
                st_d.acc    = rd_data_i;
                st_d.done   = 1'b1;
                st_d.cycles = st_q.cnt + CW'(1);
                st_d.state  = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o = (st_q.state == ST_READ);
    assign busy_o   = (st_q.state != ST_IDLE);
    assign acc_o    = st_q.acc;
    assign done_o   = st_q.done;
    assign cycles_o = st_q.cycles;

    // R4: a read is followed by done and the sampled byte in the accumulator
    assert_load_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (done_o && acc_o == $past(rd_data_i)));

    // R4: done never lasts two cycles
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the direct form reads right after its single operand byte
    assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_OPLO && !st_q.abs_mode) |=> rd_req_o);

    // R5: reported count matches the mode of the finished load
    assert_cycle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cycles_o == (st_q.abs_mode ? CW'(4) : CW'(3))));

    // R9: a start while busy does not alter the mode in flight
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(st_q.abs_mode));

endmodule

// File: rtl/dp_ea_gen.sv
module dp_ea_gen #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_abs_i,
    input  logic [DW-1:0] instr_byte_i,
    input  logic          base_we_i,
    input  logic [AW-1:0] base_wdata_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [DW-1:0] acc_o,
    output logic          done_o,
    output logic          busy_o,
    output logic [CW-1:0] cycles_o
);

    logic          capture;
    logic          ld_lo;
    logic          ld_hi;
    logic          ld_dir;
    logic [AW-1:0] base_act;

    dp_base_reg #(.AW(AW)) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (base_we_i),
        .wdata_i    (base_wdata_i),
        .capture_i  (capture),
        .base_act_o (base_act)
    );

    dp_ea_form #(.AW(AW), .DW(DW)) u_form (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo_i  (ld_lo),
        .ld_hi_i  (ld_hi),
        .ld_dir_i (ld_dir),
        .byte_i   (instr_byte_i),
        .base_i   (base_act),
        .ea_o     (rd_addr_o)
    );

    dp_ea_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_abs_i (mode_abs_i),
        .rd_data_i  (rd_data_i),
        .capture_o  (capture),
        .ld_lo_o    (ld_lo),
        .ld_hi_o    (ld_hi),
        .ld_dir_o   (ld_dir),
        .rd_req_o   (rd_req_o),
        .busy_o     (busy_o),
        .acc_o      (acc_o),
        .done_o     (done_o),
        .cycles_o   (cycles_o)
    );

    // R1: nothing is requested straight out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_req_o && !done_o && !busy_o));

endmodule

// File: tb/dp_ea_gen_tb.sv
module dp_ea_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        mode_abs_i;
    logic [7:0]  instr_byte_i;
    logic        base_we_i;
    logic [15:0] base_wdata_i;
    logic [7:0]  rd_data_i;
    logic        rd_req_o;
    logic [15:0] rd_addr_o;
    logic [7:0]  acc_o;
    logic        done_o;
    logic        busy_o;
    logic [2:0]  cycles_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference state
    logic [15:0] m_base = 16'h0000;
    logic [7:0]  m_acc  = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign rd_data_i = mem_f(rd_addr_o);

    dp_ea_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_abs_i   (mode_abs_i),
        .instr_byte_i (instr_byte_i),
        .base_we_i    (base_we_i),
        .base_wdata_i (base_wdata_i),
        .rd_data_i    (rd_data_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .acc_o        (acc_o),
        .done_o       (done_o),
        .busy_o       (busy_o),
        .cycles_o     (cycles_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        chk(busy_o == 1'b0, req, "busy idle", busy_o, 0);
        chk(rd_req_o == 1'b0, req, "rd_req idle", rd_req_o, 0);
    endtask

    task automatic write_base(input logic [15:0] v);
        @(negedge clk);
        idle_outputs("R6");
        base_we_i    = 1'b1;
        base_wdata_i = v;
        @(negedge clk);
        base_we_i = 1'b0;
        m_base    = v;
    endtask

    // One load. mid_we writes mid_val during the operand cycle; spur raises a stray start.
    task automatic run_load(input bit abs_m, input logic [7:0] lo, input logic [7:0] hi,
                            input bit mid_we, input logic [15:0] mid_val,
                            input bit spur, input string req);
        logic [15:0] ea;
        ea = abs_m ? {hi, lo} : (m_base + {8'h00, lo});
        // opcode cycle
        @(negedge clk);
        idle_outputs(req);
        chk(done_o == 1'b0, "R4", "done low between loads", done_o, 0);
        start_i      = 1'b1;
        mode_abs_i   = abs_m;
        instr_byte_i = abs_m ? 8'hAD : 8'hA5;
        // first operand cycle
        @(negedge clk);
        chk(busy_o == 1'b1, req, "busy operand", busy_o, 1);
        chk(rd_req_o == 1'b0, req, "no read in operand cycle", rd_req_o, 0);
        start_i      = spur;
        mode_abs_i   = spur ? !abs_m : abs_m;
        instr_byte_i = lo;
        if (mid_we) begin
            base_we_i    = 1'b1;
            base_wdata_i = mid_val;
        end
        if (abs_m) begin
            @(negedge clk);
            start_i   = 1'b0;
            base_we_i = 1'b0;
            if (mid_we) m_base = mid_val;
            chk(busy_o == 1'b1, "R3", "busy high byte", busy_o, 1);
            chk(rd_req_o == 1'b0, "R3", "no read in high byte cycle", rd_req_o, 0);
            instr_byte_i = hi;
        end
        // read cycle
        @(negedge clk);
        start_i      = 1'b0;
        base_we_i    = 1'b0;
        if (mid_we) m_base = mid_val;
        instr_byte_i = 8'hEE;
        chk(rd_req_o == 1'b1, req, "read request", rd_req_o, 1);
        chk(rd_addr_o == ea, req, "read address", rd_addr_o, ea);
        m_acc = mem_f(ea);
        // completion cycle
        @(negedge clk);
        chk(done_o == 1'b1, "R4", "done pulse", done_o, 1);
        chk(acc_o == m_acc, "R4", "accumulator", acc_o, m_acc);
        chk(cycles_o == (abs_m ? 3'd4 : 3'd3), "R5", "cycle count", cycles_o, abs_m ? 4 : 3);
        chk(busy_o == 1'b0, spur ? "R9" : req, "busy after load", busy_o, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] acc_dir;
        rst_n        = 1'b0;
        start_i      = 1'b0;
        mode_abs_i   = 1'b0;
        instr_byte_i = 8'h00;
        base_we_i    = 1'b0;
        base_wdata_i = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(acc_o == 8'h00, "R1", "acc after reset", acc_o, 0);
        chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        idle_outputs("R1");

        // R2, R8: direct 0x12 with base zero
        run_load(1'b0, 8'h12, 8'h00, 1'b0, 16'h0, 1'b0, "R2");
        acc_dir = acc_o;
        // R3, R8: absolute 0x0012
        run_load(1'b1, 8'h12, 8'h00, 1'b0, 16'h0, 1'b0, "R3");
        chk(acc_o == acc_dir, "R8", "direct/absolute same value", acc_o, acc_dir);
        // R3: low byte first
        run_load(1'b1, 8'h34, 8'hAB, 1'b0, 16'h0, 1'b0, "R3");
        run_load(1'b1, 8'hFF, 8'h00, 1'b0, 16'h0, 1'b0, "R3");

        // R6: base write between loads
        write_base(16'h2000);
        run_load(1'b0, 8'h12, 8'h00, 1'b0, 16'h0, 1'b0, "R6");
        run_load(1'b0, 8'hFF, 8'h00, 1'b0, 16'h0, 1'b0, "R2");

        // R8: nonzero base keeps direct loads off page zero
        write_base(16'h0100);
        run_load(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b0, "R8");
        chk(rd_addr_o >= 16'h0100, "R8", "not page zero", rd_addr_o, 16'h0100);

        // R7: wrap
        write_base(16'hFFF0);
        run_load(1'b0, 8'h20, 8'h00, 1'b0, 16'h0, 1'b0, "R7");
        chk(rd_addr_o == 16'h0010, "R7", "wrapped address", rd_addr_o, 16'h0010);

        // R6: write during a load affects only the next one
        run_load(1'b0, 8'h05, 8'h00, 1'b1, 16'h0400, 1'b0, "R6");
        run_load(1'b0, 8'h05, 8'h00, 1'b0, 16'h0, 1'b0, "R6");
        run_load(1'b1, 8'h77, 8'h12, 1'b1, 16'h0800, 1'b0, "R6");
        run_load(1'b0, 8'h80, 8'h00, 1'b0, 16'h0, 1'b0, "R6");

        // R9: stray start while busy, both modes
        run_load(1'b0, 8'h44, 8'h00, 1'b0, 16'h0, 1'b1, "R9");
        @(negedge clk);
        idle_outputs("R9");
        chk(done_o == 1'b0, "R9", "no second load", done_o, 0);
        run_load(1'b1, 8'h01, 8'h90, 1'b0, 16'h0, 1'b1, "R9");
        @(negedge clk);
        idle_outputs("R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule